// File: doc/BRIEF.md
# Five-Stage Integer Pipeline Core Without Hazard Logic

This block is a 32-bit in-order processor core built as five stages: fetch, decode, execute, memory access and writeback. A clocked register sits between each pair of neighbouring stages, so an instruction moves forward one stage on every rising clock edge. The core runs a small integer subset of the MIPS instruction set. It fetches from an internal instruction store and loads and stores to an internal word-indexed data store. The contents of both stores are set through parameters when the core is instantiated.

The core has no forwarding, no interlock and no stall logic. The writeback stage writes the register file directly, and no register sits on that path. A result therefore becomes readable by the decode stage only four instruction slots after its producer. Software must place three NOPs between dependent instructions. The only outputs are two observation buses: the execute-stage ALU value and the writeback-stage result.

Top module: `pipe5_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, every pipeline register and every general register. While reset is held and on the cycle after it, `alu_out` and `wb_out` are both 0.
- R2: Counting the rising edges after `rst` is released from 1, the instruction in word k appears on `alu_out` after edge k+2 and on `wb_out` after edge k+4. The writeback value therefore trails the ALU value by exactly two cycles. The program counter advances one word per cycle.
- R3: ADD (funct 0x20), SUB (0x22), ADDI (opcode 0x08, sign-extended immediate) and MULTU (funct 0x19) write their result to the destination register, with wrap-around and no traps. MULTU writes the low 32 bits of the unsigned product to rd.
- R4: AND (0x24), OR (0x25) and XOR (0x26) combine two registers. ANDI (0x0C), ORI (0x0D) and XORI (0x0E) zero-extend their 16-bit immediate.
- R5: SLLV (0x04), SRLV (0x06) and SRAV (0x07) shift rt by rs[4:0] and write the result to rd. A shift of 7 left by 3 gives 56. SRAV replicates the sign bit.
- R6: LW (0x23) and SW (0x2B) form the address rs + sign-extended immediate. This address appears on `alu_out`. The data store is indexed in words by the low address bits. SW writes rt, does not change any register and shows the address on `wb_out`. LW writes the loaded word to rt and shows it on `wb_out`. A load placed directly after a store to the same word returns the stored value.
- R7: Register 0 always reads as zero. A write aimed at it still shows its value on the output buses, but it leaves register 0 unchanged.
- R8: The register file is written on the edge that ends the writeback stage. An instruction four or more slots after its producer sees the new value. An instruction only three slots later (two NOPs between them) reads the old value.
- R9: Encodings follow the standard field layout: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], immediate [15:0], funct [5:0]. R-type instructions use opcode 0. Any word that does not match a listed instruction, including 0x00000000, acts as a NOP: ALU value 0, no register write and no store.
- R10: When the program counter is at or beyond `IMEM_WORDS`, fetch delivers a NOP.
- R11: Reset loads the data store from the parameter `DMEM_INIT`. Word i holds bits [32i+31:32i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_out | output | 32 | ALU value of the instruction now in execute |
| wb_out | output | 32 | Value of the instruction now in writeback |

## Verification
The core has no state outputs, so a corrupted register or pipeline entry shows up only when a later instruction uses it. A wrong general register appears on `alu_out` in the execute cycle of the first consumer. That is at least four slots after the bad write. A fault in the memory-to-writeback path appears on `wb_out` two cycles after the correct `alu_out`. A timing slip of even one stage shifts every nonzero value by a cycle, which compare-on-every-clock against a slot-accurate model catches at once. The two-NOP case tells a core that follows the required timing apart from one that has gained an unintended bypass.

// File: rtl/pipe5_pkg.sv
`timescale 1ns/1ps
package pipe5_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;
    localparam int NREG = 1 << RIDX;
    localparam int SHW  = $clog2(XLEN);

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RIDX-1:0] ridx_t;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_XORI  = 6'h0E;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;

    localparam logic [5:0] FN_SLLV  = 6'h04;
    localparam logic [5:0] FN_SRLV  = 6'h06;
    localparam logic [5:0] FN_SRAV  = 6'h07;
    localparam logic [5:0] FN_MULTU = 6'h19;
    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_SUB   = 6'h22;
    localparam logic [5:0] FN_AND   = 6'h24;
    localparam logic [5:0] FN_OR    = 6'h25;
    localparam logic [5:0] FN_XOR   = 6'h26;

    typedef enum logic [3:0] {
        ALU_NONE, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR,
        ALU_XOR, ALU_SLL, ALU_SRL, ALU_SRA, ALU_MUL
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG, SRCB_SEXT, SRCB_ZEXT
    } srcb_e;

    typedef struct packed {
        alu_op_e op;
        logic    swap;     // shifts: value from rt, amount from rs
        srcb_e   srcb;
        logic    dst_rd;
        logic    rf_we;
        logic    mem_we;
        logic    mem_rd;
    } ctrl_t;

    typedef struct packed {
        alu_op_e op;
        word_t   a;
        word_t   b;
        word_t   st;
        ridx_t   dst;
        logic    rf_we;
        logic    mem_we;
        logic    mem_rd;
    } idex_t;

    typedef struct packed {
        word_t alu;
        word_t st;
        ridx_t dst;
        logic  rf_we;
        logic  mem_we;
        logic  mem_rd;
    } exmem_t;

    typedef struct packed {
        word_t alu;
        word_t ld;
        ridx_t dst;
        logic  rf_we;
        logic  is_load;
    } memwb_t;

    function automatic word_t sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic word_t zext16(input logic [15:0] v);
        return {{(XLEN-16){1'b0}}, v};
    endfunction

    function automatic ctrl_t decode_ctrl(input logic [5:0] opc, input logic [5:0] fn);
        ctrl_t c;
        c = '0;
        case (opc)
            OPC_RTYPE: begin
                c.dst_rd = 1'b1;
                c.rf_we  = 1'b1;
                case (fn)
                    FN_ADD:   c.op = ALU_ADD;
                    FN_SUB:   c.op = ALU_SUB;
                    FN_AND:   c.op = ALU_AND;
                    FN_OR:    c.op = ALU_OR;
                    FN_XOR:   c.op = ALU_XOR;
                    FN_MULTU: c.op = ALU_MUL;
                    FN_SLLV:  begin c.op = ALU_SLL; c.swap = 1'b1; end
                    FN_SRLV:  begin c.op = ALU_SRL; c.swap = 1'b1; end
                    FN_SRAV:  begin c.op = ALU_SRA; c.swap = 1'b1; end
                    default:  c = '0;
                endcase
            end
            OPC_ADDI: begin c.op = ALU_ADD; c.srcb = SRCB_SEXT; c.rf_we = 1'b1; end
            OPC_ANDI: begin c.op = ALU_AND; c.srcb = SRCB_ZEXT; c.rf_we = 1'b1; end
            OPC_ORI:  begin c.op = ALU_OR;  c.srcb = SRCB_ZEXT; c.rf_we = 1'b1; end
            OPC_XORI: begin c.op = ALU_XOR; c.srcb = SRCB_ZEXT; c.rf_we = 1'b1; end
            OPC_LW: begin
                c.op = ALU_ADD; c.srcb = SRCB_SEXT; c.rf_we = 1'b1; c.mem_rd = 1'b1;
            end
            OPC_SW: begin
                c.op = ALU_ADD; c.srcb = SRCB_SEXT; c.mem_we = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic word_t alu_eval(input alu_op_e op, input word_t a, input word_t b);
        word_t r;
        case (op)
            ALU_ADD: r = a + b;
            ALU_SUB: r = a - b;
            ALU_AND: r = a & b;
            ALU_OR:  r = a | b;
            ALU_XOR: r = a ^ b;
            ALU_SLL: r = a << b[SHW-1:0];
            ALU_SRL: r = a >> b[SHW-1:0];
            ALU_SRA: r = word_t'($signed(a) >>> b[SHW-1:0]);
            ALU_MUL: r = a * b;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pipe5_fetch.sv
`timescale 1ns/1ps
module pipe5_fetch
    import pipe5_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter logic [IMEM_WORDS-1:0][XLEN-1:0] IMEM_INIT = '0
) (
    input  logic  clk,
    input  logic  rst,
    output word_t pc,
    output word_t fetch_word,
    output word_t ifid_instr
);
    localparam int IW = (IMEM_WORDS > 1) ? $clog2(IMEM_WORDS) : 1;

    word_t pc_q;
    word_t ifid_q;

    always_comb begin
        if (pc_q < word_t'(IMEM_WORDS))
            fetch_word = IMEM_INIT[pc_q[IW-1:0]];
        else
            fetch_word = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            ifid_q <= '0;
        end else begin
            pc_q   <= pc_q + word_t'(1);
            ifid_q <= fetch_word;
        end
    end

    assign pc         = pc_q;
    assign ifid_instr = ifid_q;

endmodule

// File: rtl/pipe5_decode.sv
`timescale 1ns/1ps
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t instr,
    input  logic  wb_we,
    input  ridx_t wb_dst,
    input  word_t wb_data,
    output idex_t idex,
    output word_t r0_val
);
    word_t regs [NREG];
    idex_t idex_n;
    idex_t idex_q;
    ctrl_t c;
    ridx_t rs, rt, rd;
    logic [15:0] imm;
    word_t rs_v, rt_v;

    // register file; writeback drives it with no pipeline register between
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wb_we && (wb_dst != '0)) begin
            regs[wb_dst] <= wb_data;
        end
    end

    always_comb begin
        rs   = instr[25:21];
        rt   = instr[20:16];
        rd   = instr[15:11];
        imm  = instr[15:0];
        c    = decode_ctrl(instr[31:26], instr[5:0]);
        rs_v = regs[rs];
        rt_v = regs[rt];

        idex_n.op     = c.op;
        idex_n.a      = c.swap ? rt_v : rs_v;
        case (c.srcb)
            SRCB_SEXT: idex_n.b = sext16(imm);
            SRCB_ZEXT: idex_n.b = zext16(imm);
            default:   idex_n.b = c.swap ? rs_v : rt_v;
        endcase
        idex_n.st     = rt_v;
        idex_n.dst    = c.dst_rd ? rd : rt;
        idex_n.rf_we  = c.rf_we;
        idex_n.mem_we = c.mem_we;
        idex_n.mem_rd = c.mem_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) idex_q <= '0;
        else     idex_q <= idex_n;
    end

    assign idex   = idex_q;
    assign r0_val = regs[0];

endmodule

// File: rtl/pipe5_execute.sv
`timescale 1ns/1ps
module pipe5_execute
    import pipe5_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  idex_t  idex,
    output word_t  alu_res,
    output exmem_t exmem
);
    exmem_t exmem_q;

    assign alu_res = alu_eval(idex.op, idex.a, idex.b);

    always_ff @(posedge clk) begin
        if (rst) begin
            exmem_q <= '0;
        end else begin
            exmem_q.alu    <= alu_res;
            exmem_q.st     <= idex.st;
            exmem_q.dst    <= idex.dst;
            exmem_q.rf_we  <= idex.rf_we;
            exmem_q.mem_we <= idex.mem_we;
            exmem_q.mem_rd <= idex.mem_rd;
        end
    end

    assign exmem = exmem_q;

endmodule

// File: rtl/pipe5_memory.sv
`timescale 1ns/1ps
module pipe5_memory
    import pipe5_pkg::*;
#(
    parameter int DMEM_WORDS = 16,
    parameter logic [DMEM_WORDS-1:0][XLEN-1:0] DMEM_INIT = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  exmem_t exmem,
    output memwb_t memwb
);
    localparam int DW = (DMEM_WORDS > 1) ? $clog2(DMEM_WORDS) : 1;

    word_t          store_q [DMEM_WORDS];
    logic [DW-1:0]  idx;
    word_t          rdata;
    memwb_t         memwb_q;
    logic           unused_addr_hi;

    assign idx            = exmem.alu[DW-1:0];
    assign unused_addr_hi = ^exmem.alu[XLEN-1:DW];
    assign rdata          = store_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DMEM_WORDS; i++) store_q[i] <= DMEM_INIT[i];
        end else if (exmem.mem_we) begin
            store_q[idx] <= exmem.st;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            memwb_q <= '0;
        end else begin
            memwb_q.alu     <= exmem.alu;
            memwb_q.ld      <= exmem.mem_rd ? rdata : '0;
            memwb_q.dst     <= exmem.dst;
            memwb_q.rf_we   <= exmem.rf_we;
            memwb_q.is_load <= exmem.mem_rd;
        end
    end

    assign memwb = memwb_q;

endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 16,
    parameter logic [IMEM_WORDS-1:0][XLEN-1:0] IMEM_INIT = '0,
    parameter logic [DMEM_WORDS-1:0][XLEN-1:0] DMEM_INIT = '0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] alu_out,
    output logic [XLEN-1:0] wb_out
);
    word_t  fetch_pc;
    word_t  fetch_word;
    word_t  ifid_instr;
    idex_t  idex;
    word_t  alu_res;
    exmem_t exmem;
    memwb_t memwb;
    word_t  wb_data;
    word_t  r0_val;
    logic   wb_is_load;
    logic   em_mem_we;
    logic   em_rf_we;

    pipe5_fetch #(
        .IMEM_WORDS (IMEM_WORDS),
        .IMEM_INIT  (IMEM_INIT)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .pc         (fetch_pc),
        .fetch_word (fetch_word),
        .ifid_instr (ifid_instr)
    );

    pipe5_decode u_decode (
        .clk     (clk),
        .rst     (rst),
        .instr   (ifid_instr),
        .wb_we   (memwb.rf_we),
        .wb_dst  (memwb.dst),
        .wb_data (wb_data),
        .idex    (idex),
        .r0_val  (r0_val)
    );

    pipe5_execute u_execute (
        .clk     (clk),
        .rst     (rst),
        .idex    (idex),
        .alu_res (alu_res),
        .exmem   (exmem)
    );

    pipe5_memory #(
        .DMEM_WORDS (DMEM_WORDS),
        .DMEM_INIT  (DMEM_INIT)
    ) u_memory (
        .clk   (clk),
        .rst   (rst),
        .exmem (exmem),
        .memwb (memwb)
    );

    // writeback stage: select and hand straight to the register file
    assign wb_data    = memwb.is_load ? memwb.ld : memwb.alu;
    assign wb_is_load = memwb.is_load;
    assign em_mem_we  = exmem.mem_we;
    assign em_rf_we   = exmem.rf_we;

    assign alu_out = alu_res;
    assign wb_out  = wb_data;

endmodule

// File: rtl/pipe5_core_chk.sv
`timescale 1ns/1ps
module pipe5_core_chk
    import pipe5_pkg::*;
#(
    parameter int IMEM_WORDS = 64
) (
    input logic  clk,
    input logic  rst,
    input word_t alu_out,
    input word_t wb_out,
    input logic  wb_is_load,
    input word_t fetch_pc,
    input word_t fetch_word,
    input logic  em_mem_we,
    input logic  em_rf_we,
    input word_t r0_val
);
    logic       rst_d;
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_d === 1'b1) begin
            reset_clear_chk: assert (alu_out == '0 && wb_out == '0)
                else $error("outputs not cleared after reset");
        end
    end

    // R2
    wb_lag_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !wb_is_load) |-> (wb_out == $past(alu_out, 2)))
        else $error("writeback value does not trail ALU value by two cycles");

    // R10
    fetch_tail_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_pc >= word_t'(IMEM_WORDS)) |-> (fetch_word == '0))
        else $error("fetch beyond program end is not a NOP");

    // R6
    store_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        em_mem_we |-> !em_rf_we)
        else $error("store also requests a register write");

    // R7
    always_ff @(posedge clk) begin
        if (rst === 1'b0) begin
            r0_zero_chk: assert (r0_val == '0)
                else $error("register 0 changed");
        end
    end

endmodule

bind pipe5_core pipe5_core_chk #(
    .IMEM_WORDS (IMEM_WORDS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .alu_out    (alu_out),
    .wb_out     (wb_out),
    .wb_is_load (wb_is_load),
    .fetch_pc   (fetch_pc),
    .fetch_word (fetch_word),
    .em_mem_we  (em_mem_we),
    .em_rf_we   (em_rf_we),
    .r0_val     (r0_val)
);

// File: tb/pipe5_core_tb.sv
`timescale 1ns/1ps
module pipe5_core_tb;
    import pipe5_pkg::*;

    localparam int IMW  = 128;
    localparam int DMW  = 16;
    localparam int NCYC = 150;
    localparam int SLOT_R0W  = 68;
    localparam int SLOT_R0R  = 72;
    localparam int SLOT_HAZ  = 79;
    localparam int SLOT_INIT = 100;

    function automatic word_t enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic word_t enc_i(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [IMW-1:0][31:0] build_prog();
        logic [IMW-1:0][31:0] p;
        p = '0;
        p[0]  = enc_i(OPC_ORI, 1, 0, 16'd7);
        p[4]  = enc_i(OPC_ORI, 2, 0, 16'd3);
        p[8]  = enc_r(FN_SLLV, 3, 2, 1);          // 7 << 3
        p[12] = enc_i(OPC_ORI, 4, 0, 16'd4);
        p[16] = enc_r(FN_SUB, 5, 4, 3);           // 4 - 56
        p[20] = enc_i(OPC_ADDI, 6, 0, 16'hFFF8);  // -8
        p[24] = enc_r(FN_SRAV, 7, 2, 6);
        p[28] = enc_r(FN_SRLV, 8, 2, 6);
        p[32] = enc_i(OPC_XORI, 9, 6, 16'hFFFF);
        p[36] = enc_i(OPC_ANDI, 10, 6, 16'h00F0);
        p[40] = enc_r(FN_AND, 11, 6, 1);
        p[44] = enc_r(FN_OR, 12, 6, 1);
        p[48] = enc_r(FN_XOR, 13, 5, 3);
        p[52] = enc_r(FN_MULTU, 14, 6, 3);
        p[56] = enc_r(FN_ADD, 15, 5, 3);
        p[60] = enc_i(OPC_SW, 12, 2, 16'd2);      // address 5
        p[64] = enc_i(OPC_LW, 16, 0, 16'd5);
        p[SLOT_R0W] = enc_i(OPC_ADDI, 0, 0, 16'd9);
        p[SLOT_R0R] = enc_r(FN_ADD, 17, 0, 1);
        p[76] = enc_i(OPC_ORI, 18, 0, 16'd100);
        p[SLOT_HAZ] = enc_r(FN_ADD, 19, 18, 18); // only two NOPs after producer
        p[83] = enc_r(FN_ADD, 20, 18, 18);
        p[87] = enc_i(OPC_ADDI, 21, 2, 16'hFFFB);
        p[91] = enc_i(OPC_SW, 20, 2, 16'hFFFF);   // address 2
        p[92] = enc_i(OPC_LW, 22, 0, 16'd2);      // load right after store
        p[96] = enc_r(FN_ADD, 23, 22, 0);
        p[SLOT_INIT] = enc_i(OPC_LW, 24, 0, 16'd7);
        p[104] = 32'hFC00_0000;                   // unknown opcode
        p[108] = enc_r(6'h3F, 25, 1, 2);          // unknown funct
        return p;
    endfunction

    function automatic logic [DMW-1:0][31:0] build_dmem();
        logic [DMW-1:0][31:0] d;
        for (int i = 0; i < DMW; i++) d[i] = 32'(i) * 32'h0101_0101;
        d[7] = 32'h1234_ABCD;
        return d;
    endfunction

    localparam logic [IMW-1:0][31:0] PROG  = build_prog();
    localparam logic [DMW-1:0][31:0] DINIT = build_dmem();

    logic  clk;
    logic  rst;
    word_t alu_out;
    word_t wb_out;

    pipe5_core #(
        .IMEM_WORDS (IMW),
        .DMEM_WORDS (DMW),
        .IMEM_INIT  (PROG),
        .DMEM_INIT  (DINIT)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .alu_out (alu_out),
        .wb_out  (wb_out)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int    n_checks = 0;
    int    n_err    = 0;
    bit    done     = 1'b0;
    word_t exp_alu [IMW];
    word_t exp_wb  [IMW];
    string tag     [IMW];

    task automatic check(input string req, input string what, input word_t act, input word_t exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // slot-accurate behavioural model: a write lands four slots after its producer
    task automatic run_model();
        word_t regs [32];
        word_t dm   [DMW];
        bit    wen  [IMW];
        int    wdst [IMW];
        word_t wval [IMW];
        for (int i = 0; i < 32; i++) regs[i] = '0;
        for (int i = 0; i < DMW; i++) dm[i] = DINIT[i];
        for (int k = 0; k < IMW; k++) begin
            word_t w, va, vb, se, ze, res, wbv;
            int rs, rt, rd, dst;
            bit we;
            string t;
            if (k >= 4 && wen[k-4] && wdst[k-4] != 0) regs[wdst[k-4]] = wval[k-4];
            w  = PROG[k];
            rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
            va = regs[rs]; vb = regs[rt];
            se = {{16{w[15]}}, w[15:0]};
            ze = {16'd0, w[15:0]};
            res = '0; we = 1'b0; dst = rt; t = "R9";
            if (w[31:26] == 6'h00) begin
                dst = rd; we = 1'b1;
                case (w[5:0])
                    6'h20: begin res = va + vb; t = "R3"; end
                    6'h22: begin res = va - vb; t = "R3"; end
                    6'h19: begin res = va * vb; t = "R3"; end
                    6'h24: begin res = va & vb; t = "R4"; end
                    6'h25: begin res = va | vb; t = "R4"; end
                    6'h26: begin res = va ^ vb; t = "R4"; end
                    6'h04: begin res = vb << va[4:0]; t = "R5"; end
                    6'h06: begin res = vb >> va[4:0]; t = "R5"; end
                    6'h07: begin res = word_t'($signed(vb) >>> va[4:0]); t = "R5"; end
                    default: we = 1'b0;
                endcase
                wbv = res;
            end else begin
                case (w[31:26])
                    6'h08: begin res = va + se; we = 1'b1; t = "R3"; end
                    6'h0C: begin res = va & ze; we = 1'b1; t = "R4"; end
                    6'h0D: begin res = va | ze; we = 1'b1; t = "R4"; end
                    6'h0E: begin res = va ^ ze; we = 1'b1; t = "R4"; end
                    6'h23: begin res = va + se; we = 1'b1; t = "R6"; end
                    6'h2B: begin res = va + se; t = "R6"; dm[res % DMW] = vb; end
                    default: res = '0;
                endcase
                wbv = (w[31:26] == 6'h23) ? dm[res % DMW] : res;
            end
            exp_alu[k] = res;
            exp_wb[k]  = wbv;
            wen[k] = we; wdst[k] = dst; wval[k] = wbv;
            tag[k] = t;
        end
        tag[SLOT_R0W]  = "R7";
        tag[SLOT_R0R]  = "R7";
        tag[SLOT_HAZ]  = "R8";
        tag[SLOT_INIT] = "R11";
    endtask

    initial begin
        rst = 1'b1;
        run_model();
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "alu_out in reset", alu_out, '0);
        check("R1", "wb_out in reset", wb_out, '0);
        rst = 1'b0;
        for (int e = 1; e <= NCYC; e++) begin
            int ka, kw;
            word_t ea, ew;
            string ta, tw;
            @(negedge clk);
            ka = e - 2;
            kw = e - 4;
            // R2: slot k on alu_out after edge k+2, on wb_out after edge k+4
            if (ka < 0)          begin ea = '0; ta = "R1"; end
            else if (ka >= IMW)  begin ea = '0; ta = "R10"; end
            else                 begin ea = exp_alu[ka]; ta = tag[ka]; end
            if (kw < 0)          begin ew = '0; tw = "R2/R1"; end
            else if (kw >= IMW)  begin ew = '0; tw = "R2/R10"; end
            else                 begin ew = exp_wb[kw]; tw = {"R2/", tag[kw]}; end
            check(ta, $sformatf("alu_out cycle %0d", e), alu_out, ea);
            check(tw, $sformatf("wb_out cycle %0d", e), wb_out, ew);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule